// File: doc/BRIEF.md
# Smart card line timing sequencer

This block drives the contact lines of a smart card slot through the card's whole life cycle. From a single system clock it produces the card clock, using a programmable divisor. It brings the card up in a fixed order: supply, then the I/O line, then the clock, then the reset release. It performs warm resets on a card that is already powered. It shuts the contacts down in the reverse order. Every phase lasts a programmable number of timing units. One unit is 128 card clock periods.

After each reset release the block opens a window in which the card must begin its answer-to-reset. The first falling edge on the card I/O line inside that window marks the answer as started. If the window closes with no edge, a timeout flag is raised. Either way the sequencer settles in a ready state. From there the controlling logic may request a warm reset or a deactivation. Character reception and framing are done elsewhere.

Top module: `sc_line_seq`

## Requirements
- R1: A synchronous active-high `rst` drives every output low on the next clock edge: power, I/O enable, card clock, card reset line (low means reset asserted), ready and both flags.
- R2: The card clock is held low unless the sequence is in a clock-running step. Once the clock is enabled, it stays low for `clk_div_i`+1 system cycles and then toggles every `clk_div_i`+1 system cycles. Its period is therefore 2×(`clk_div_i`+1) system cycles. It is forced low one cycle after the clock step ends.
- R3: One timing unit is 128 card clock periods, which is 256×(`clk_div_i`+1) system cycles. `timing_i` carries the step time in bits 7:0, the reset time in bits 15:8 and the answer window in bits 23:16. A field value of 0 counts as 1 unit.
- R4: An activate request in the off state raises power on the next edge. The I/O enable follows one step-time later and the clock-running step one further step-time later.
- R5: A cold reset keeps the card reset line low for the reset time, counted from the start of the clock step. The line is then released.
- R6: The answer window opens when the reset line is released and clears both flags. A falling edge on `card_io_i` reaches the sequencer through two synchronizer stages and an edge register, so it takes effect on the third edge after the line falls. If the window is still open, it sets `atr_seen_o`, closes the window and enters the ready state.
- R7: If no falling edge arrives within the answer window, `atr_timeout_o` is set when the window ends and the ready state is entered. The two flags then hold until the next window opens.
- R8: A warm request in the ready state pulls the reset line low on the next edge while power, I/O enable and clock keep running. After the reset time the line is released and a new answer window opens.
- R9: A deactivate request in any powered state that is not already shutting down pulls the reset line low on the next edge. The clock step ends one step-time later, the I/O enable drops one step-time after that, and power drops after a third step-time. No line is ever raised during shutdown.
- R10: Requests outside their state have no effect: activate while powered, warm reset outside the ready state, and a deactivate or warm request while off. I/O edges outside the answer window have no effect either.
- R11: `seq_ready_o` is high exactly while the sequencer sits in the ready state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| act_req_i | input | 1 | Request to bring the card up |
| deact_req_i | input | 1 | Request to shut the card down |
| warm_req_i | input | 1 | Request for a warm reset |
| clk_div_i | input | 16 | Card clock divisor |
| timing_i | input | 24 | Answer window [23:16], reset time [15:8], step time [7:0] |
| card_io_i | input | 1 | Card I/O line as received |
| card_clk_o | output | 1 | Card clock |
| card_rstn_o | output | 1 | Card reset line, low = reset asserted |
| card_pwr_o | output | 1 | Card supply enable |
| card_io_en_o | output | 1 | I/O line enable (reception mode) |
| seq_ready_o | output | 1 | Sequencer in ready state |
| atr_seen_o | output | 1 | Answer start detected in the last window |
| atr_timeout_o | output | 1 | Last answer window expired |

## Verification
The sequence is run with two divisor and field settings. The first uses a divisor of 0 with distinct step, reset and window values, so a swap of two fields shows up as a shifted edge. The second uses a divisor of 2 with zero-valued fields, which separates correct unit scaling and zero-as-one handling from off-by-one counting. The answer window is exercised with an early I/O edge, with no edge at all, and with edges that arrive after it closes. A deactivation is also issued in mid-activation and again from the ready state, and the bench compares every output against a behavioural model on each cycle.

// File: rtl/sc_line_pkg.sv
package sc_line_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_PWR,
    ST_IO,
    ST_CLK,
    ST_ATR,
    ST_READY,
    ST_WARM,
    ST_D_RST,
    ST_D_CLK,
    ST_D_IO
  } seq_state_e;

  typedef enum logic [1:0] {
    LIM_STEP,
    LIM_RESET,
    LIM_WINDOW
  } lim_sel_e;

  typedef struct packed {
    logic pwr;
    logic io_en;
    logic clk_en;
    logic rst_n;
  } line_t;

  localparam line_t LINES_OFF = '{pwr: 1'b0, io_en: 1'b0, clk_en: 1'b0, rst_n: 1'b0};

endpackage

// File: rtl/sc_unit_timer.sv
module sc_unit_timer #(
  parameter int DIV_W   = 16,
  parameter int PRESC_W = 7,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  localparam logic [PRESC_W-1:0] PRESC_LAST = '1;
  localparam logic [PRESC_W-1:0] PRESC_ONE  = PRESC_W'(1);
  localparam logic [CNT_W-1:0]   CNT_ONE    = CNT_W'(1);
  localparam logic [DIV_W-1:0]   DIV_ONE    = DIV_W'(1);

  logic [DIV_W-1:0]   sys_q;
  logic               half_q;
  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]   units_q;
  logic [CNT_W-1:0]   lim_eff;
  logic               half_end;
  logic               unit_end;

  // half_end closes one half card period; two halves make one card cycle,
  // and 2**PRESC_W card cycles make one timing unit.
  always_comb begin
    lim_eff  = (limit == '0) ? CNT_ONE : limit;
    half_end = (sys_q == div);
    unit_end = half_end && half_q && (presc_q == PRESC_LAST);
    done     = unit_end && (units_q == lim_eff - CNT_ONE);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      sys_q   <= '0;
      half_q  <= 1'b0;
      presc_q <= '0;
      units_q <= '0;
    end else if (half_end) begin
      sys_q  <= '0;
      half_q <= ~half_q;
      if (half_q) begin
        presc_q <= presc_q + PRESC_ONE;
      end
      if (unit_end) begin
        units_q <= units_q + CNT_ONE;
      end
    end else begin
      sys_q <= sys_q + DIV_ONE;
    end
  end

endmodule

// File: rtl/sc_card_clk.sv
module sc_card_clk #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             card_clk
);

  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic             ck_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      ck_q  <= 1'b0;
    end else if (cnt_q == div) begin
      cnt_q <= '0;
      ck_q  <= ~ck_q;
    end else begin
      cnt_q <= cnt_q + DIV_ONE;
    end
  end

  assign card_clk = ck_q;

endmodule

// File: rtl/sc_io_fall.sv
module sc_io_fall #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic io_i,
  output logic fall
);

  logic [SYNC-1:0] sync_q;
  logic            prev_q;

  generate
    if (SYNC == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= io_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC-2:0], io_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_q[SYNC-1];
  end

  assign fall = prev_q & ~sync_q[SYNC-1];

endmodule

// File: rtl/sc_line_seq.sv
module sc_line_seq
  import sc_line_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int FLD_W       = 8,
  parameter int PRESC_W     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               act_req_i,
  input  logic               deact_req_i,
  input  logic               warm_req_i,
  input  logic [DIV_W-1:0]   clk_div_i,
  input  logic [3*FLD_W-1:0] timing_i,
  input  logic               card_io_i,
  output logic               card_clk_o,
  output logic               card_rstn_o,
  output logic               card_pwr_o,
  output logic               card_io_en_o,
  output logic               seq_ready_o,
  output logic               atr_seen_o,
  output logic               atr_timeout_o
);

  localparam int STEP_LO = 0;
  localparam int RST_LO  = FLD_W;
  localparam int WIN_LO  = 2 * FLD_W;

  logic [FLD_W-1:0] fld_step;
  logic [FLD_W-1:0] fld_reset;
  logic [FLD_W-1:0] fld_window;
  logic [FLD_W-1:0] limit;
  lim_sel_e         lim_sel;

  seq_state_e state_q, state_d;
  line_t      line_q, line_d;
  logic       seen_q, seen_d;
  logic       tmo_q, tmo_d;
  logic       ready_q;
  logic       restart;
  logic       phase_done;
  logic       io_fall;
  logic       shutdown_ok;

  assign fld_step   = timing_i[STEP_LO +: FLD_W];
  assign fld_reset  = timing_i[RST_LO  +: FLD_W];
  assign fld_window = timing_i[WIN_LO  +: FLD_W];

  // Which field times the current phase.
  always_comb begin
    unique case (state_q)
      ST_CLK, ST_WARM: lim_sel = LIM_RESET;
      ST_ATR:          lim_sel = LIM_WINDOW;
      default:         lim_sel = LIM_STEP;
    endcase
    unique case (lim_sel)
      LIM_RESET:  limit = fld_reset;
      LIM_WINDOW: limit = fld_window;
      default:    limit = fld_step;
    endcase
  end

  sc_unit_timer #(
    .DIV_W  (DIV_W),
    .PRESC_W(PRESC_W),
    .CNT_W  (FLD_W)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .div    (clk_div_i),
    .limit  (limit),
    .done   (phase_done)
  );

  sc_io_fall #(
    .SYNC(SYNC_STAGES)
  ) u_fall (
    .clk (clk),
    .rst (rst),
    .io_i(card_io_i),
    .fall(io_fall)
  );

  sc_card_clk #(
    .DIV_W(DIV_W)
  ) u_cclk (
    .clk     (clk),
    .rst     (rst),
    .run     (line_q.clk_en),
    .div     (clk_div_i),
    .card_clk(card_clk_o)
  );

  // Next phase.
  always_comb begin
    state_d     = state_q;
    shutdown_ok = deact_req_i;
    unique case (state_q)
      ST_OFF: begin
        if (act_req_i) state_d = ST_PWR;
      end
      ST_PWR: begin
        if (shutdown_ok)     state_d = ST_D_RST;
        else if (phase_done) state_d = ST_IO;
      end
      ST_IO: begin
        if (shutdown_ok)     state_d = ST_D_RST;
        else if (phase_done) state_d = ST_CLK;
      end
      ST_CLK: begin
        if (shutdown_ok)     state_d = ST_D_RST;
        else if (phase_done) state_d = ST_ATR;
      end
      ST_ATR: begin
        if (shutdown_ok)                state_d = ST_D_RST;
        else if (io_fall || phase_done) state_d = ST_READY;
      end
      ST_READY: begin
        if (shutdown_ok)     state_d = ST_D_RST;
        else if (warm_req_i) state_d = ST_WARM;
      end
      ST_WARM: begin
        if (shutdown_ok)     state_d = ST_D_RST;
        else if (phase_done) state_d = ST_ATR;
      end
      ST_D_RST: begin
        if (phase_done) state_d = ST_D_CLK;
      end
      ST_D_CLK: begin
        if (phase_done) state_d = ST_D_IO;
      end
      ST_D_IO: begin
        if (phase_done) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  assign restart = (state_d != state_q);

  // Line levels for the phase being entered; shutdown phases only lower lines.
  always_comb begin
    line_d = line_q;
    unique case (state_d)
      ST_OFF:           line_d = LINES_OFF;
      ST_PWR:           line_d = '{pwr: 1'b1, io_en: 1'b0, clk_en: 1'b0, rst_n: 1'b0};
      ST_IO:            line_d = '{pwr: 1'b1, io_en: 1'b1, clk_en: 1'b0, rst_n: 1'b0};
      ST_CLK:           line_d = '{pwr: 1'b1, io_en: 1'b1, clk_en: 1'b1, rst_n: 1'b0};
      ST_ATR, ST_READY: line_d = '{pwr: 1'b1, io_en: 1'b1, clk_en: 1'b1, rst_n: 1'b1};
      ST_WARM:          line_d.rst_n = 1'b0;
      ST_D_RST:         line_d.rst_n = 1'b0;
      ST_D_CLK: begin
        line_d.rst_n  = 1'b0;
        line_d.clk_en = 1'b0;
      end
      ST_D_IO: begin
        line_d.rst_n  = 1'b0;
        line_d.clk_en = 1'b0;
        line_d.io_en  = 1'b0;
      end
      default: line_d = LINES_OFF;
    endcase
  end

  // Answer window flags.
  always_comb begin
    seen_d = seen_q;
    tmo_d  = tmo_q;
    if (state_d == ST_ATR && state_q != ST_ATR) begin
      seen_d = 1'b0;
      tmo_d  = 1'b0;
    end else if (state_q == ST_ATR && state_d == ST_READY) begin
      seen_d = io_fall;
      tmo_d  = ~io_fall;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      line_q  <= LINES_OFF;
      seen_q  <= 1'b0;
      tmo_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      line_q  <= line_d;
      seen_q  <= seen_d;
      tmo_q   <= tmo_d;
      ready_q <= (state_d == ST_READY);
    end
  end

  assign card_rstn_o   = line_q.rst_n;
  assign card_pwr_o    = line_q.pwr;
  assign card_io_en_o  = line_q.io_en;
  assign seq_ready_o   = ready_q;
  assign atr_seen_o    = seen_q;
  assign atr_timeout_o = tmo_q;

endmodule

// File: rtl/sc_line_seq_chk.sv
module sc_line_seq_chk (
  input logic clk,
  input logic rst,
  input logic act_req_i,
  input logic warm_req_i,
  input logic deact_req_i,
  input logic card_clk_o,
  input logic card_rstn_o,
  input logic card_pwr_o,
  input logic card_io_en_o,
  input logic seq_ready_o,
  input logic atr_seen_o,
  input logic atr_timeout_o
);

  // R2: the card clock never runs on an unpowered card
  a_r2_clk_needs_pwr: assert property (@(posedge clk) disable iff (rst)
    card_clk_o |-> card_pwr_o);

  // R4: the I/O line is only enabled with power present
  a_r4_io_needs_pwr: assert property (@(posedge clk) disable iff (rst)
    card_io_en_o |-> card_pwr_o);

  // R4: power only comes up in answer to an activate request
  a_r4_pwr_from_request: assert property (@(posedge clk) disable iff (rst)
    $rose(card_pwr_o) |-> $past(act_req_i));

  // R5: reset is released only with power and I/O already up
  a_r5_release_after_io: assert property (@(posedge clk) disable iff (rst)
    card_rstn_o |-> (card_pwr_o && card_io_en_o));

  // R7: the two window outcomes exclude each other
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(atr_seen_o && atr_timeout_o));

  // R8: a warm request in ready keeps power and pulls reset low
  a_r8_warm_keeps_power: assert property (@(posedge clk) disable iff (rst)
    ($past(seq_ready_o) && $past(warm_req_i) && !$past(deact_req_i))
      |-> (card_pwr_o && card_io_en_o && !card_rstn_o));

  // R9: power is removed only after I/O and reset are down
  a_r9_pwr_drop_last: assert property (@(posedge clk) disable iff (rst)
    $fell(card_pwr_o) |-> (!card_io_en_o && !card_rstn_o));

  // R11: the ready state always has reset released
  a_r11_ready_released: assert property (@(posedge clk) disable iff (rst)
    seq_ready_o |-> (card_rstn_o && card_pwr_o));

endmodule

bind sc_line_seq sc_line_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .act_req_i    (act_req_i),
  .warm_req_i   (warm_req_i),
  .deact_req_i  (deact_req_i),
  .card_clk_o   (card_clk_o),
  .card_rstn_o  (card_rstn_o),
  .card_pwr_o   (card_pwr_o),
  .card_io_en_o (card_io_en_o),
  .seq_ready_o  (seq_ready_o),
  .atr_seen_o   (atr_seen_o),
  .atr_timeout_o(atr_timeout_o)
);

// File: tb/tb_sc_line_seq.sv
module tb_sc_line_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        act_req = 1'b0;
  logic        deact_req = 1'b0;
  logic        warm_req = 1'b0;
  logic [15:0] div = 16'd0;
  logic [23:0] timing = 24'd0;
  logic        io_line = 1'b1;
  logic        card_clk, card_rstn, card_pwr, card_io_en, ready, seen, tmo;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  sc_line_seq dut (
    .clk          (clk),
    .rst          (rst),
    .act_req_i    (act_req),
    .deact_req_i  (deact_req),
    .warm_req_i   (warm_req),
    .clk_div_i    (div),
    .timing_i     (timing),
    .card_io_i    (io_line),
    .card_clk_o   (card_clk),
    .card_rstn_o  (card_rstn),
    .card_pwr_o   (card_pwr),
    .card_io_en_o (card_io_en),
    .seq_ready_o  (ready),
    .atr_seen_o   (seen),
    .atr_timeout_o(tmo)
  );

  // ---------------- behavioural reference ----------------
  localparam int M_OFF = 0, M_PWR = 1, M_IO = 2, M_CLK = 3, M_WIN = 4, M_RDY = 5,
                 M_WARM = 6, M_DR = 7, M_DC = 8, M_DI = 9;
  int m_st, m_el, m_ckc;
  bit m_pwr, m_io, m_ce, m_rn, m_ck, m_seen, m_to, m_rdy;
  bit h0, h1, h2;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_st = M_OFF; m_el = 0; m_ckc = 0;
      m_pwr = 0; m_io = 0; m_ce = 0; m_rn = 0; m_ck = 0;
      m_seen = 0; m_to = 0; m_rdy = 0;
      h0 = 1; h1 = 1; h2 = 1;
    end else begin
      int u, lim, nst;
      bit fall, done;
      fall = h2 && !h1;
      if (!m_ce) begin m_ckc = 0; m_ck = 0; end
      else if (m_ckc == int'(div)) begin m_ckc = 0; m_ck = !m_ck; end
      else m_ckc++;
      h2 = h1; h1 = h0; h0 = io_line;
      u = 256 * (int'(div) + 1);
      case (m_st)
        M_CLK, M_WARM: lim = eff(int'(timing[15:8]));
        M_WIN:         lim = eff(int'(timing[23:16]));
        default:       lim = eff(int'(timing[7:0]));
      endcase
      done = (m_el == lim * u - 1);
      nst = m_st;
      case (m_st)
        M_OFF:  if (act_req) nst = M_PWR;
        M_PWR:  nst = deact_req ? M_DR : (done ? M_IO : m_st);
        M_IO:   nst = deact_req ? M_DR : (done ? M_CLK : m_st);
        M_CLK:  nst = deact_req ? M_DR : (done ? M_WIN : m_st);
        M_WIN:  nst = deact_req ? M_DR : ((fall || done) ? M_RDY : m_st);
        M_RDY:  nst = deact_req ? M_DR : (warm_req ? M_WARM : m_st);
        M_WARM: nst = deact_req ? M_DR : (done ? M_WIN : m_st);
        M_DR:   if (done) nst = M_DC;
        M_DC:   if (done) nst = M_DI;
        M_DI:   if (done) nst = M_OFF;
        default: nst = M_OFF;
      endcase
      if (nst == M_WIN && m_st != M_WIN) begin m_seen = 0; m_to = 0; end
      else if (m_st == M_WIN && nst == M_RDY) begin m_seen = fall; m_to = !fall; end
      case (nst)
        M_OFF: begin m_pwr = 0; m_io = 0; m_ce = 0; m_rn = 0; end
        M_PWR: begin m_pwr = 1; m_io = 0; m_ce = 0; m_rn = 0; end
        M_IO:  begin m_pwr = 1; m_io = 1; m_ce = 0; m_rn = 0; end
        M_CLK: begin m_pwr = 1; m_io = 1; m_ce = 1; m_rn = 0; end
        M_WIN, M_RDY: begin m_pwr = 1; m_io = 1; m_ce = 1; m_rn = 1; end
        M_WARM, M_DR: m_rn = 0;
        M_DC: begin m_rn = 0; m_ce = 0; end
        M_DI: begin m_rn = 0; m_ce = 0; m_io = 0; end
        default: ;
      endcase
      m_el = (nst != m_st) ? 0 : m_el + 1;
      m_st = nst;
      m_rdy = (nst == M_RDY);
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk("R4/R9 power vs model",      card_pwr,   m_pwr);
      chk("R4/R9 io enable vs model",  card_io_en, m_io);
      chk("R2 card clock vs model",    card_clk,   m_ck);
      chk("R5/R8 reset line vs model", card_rstn,  m_rn);
      chk("R11 ready vs model",        ready,      m_rdy);
      chk("R6 seen flag vs model",     seen,       m_seen);
      chk("R7 timeout flag vs model",  tmo,        m_to);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_act;   act_req = 1;   step(1); act_req = 0;   endtask
  task automatic pulse_deact; deact_req = 1; step(1); deact_req = 0; endtask
  task automatic pulse_warm;  warm_req = 1;  step(1); warm_req = 0;  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    int u;
    rst = 1;
    step(3);
    cmp_on = 1;
    // R1: outputs after reset
    chk("R1 power after reset", card_pwr, 0);
    chk("R1 reset line after reset", card_rstn, 0);
    chk("R1 clock after reset", card_clk, 0);
    chk("R1 flags after reset", seen | tmo | ready, 0);
    rst = 0;
    step(2);

    // ---- configuration 1: divisor 0, step 1, reset 2, window 3 ----
    div = 16'd0; timing = {8'd3, 8'd2, 8'd1}; u = 256;
    pulse_act;
    chk("R4 power on after request", card_pwr, 1);
    chk("R4 io still off", card_io_en, 0);
    chk("R2 clock low before clock step", card_clk, 0);
    step(u - 1);
    chk("R4 io off at end of first step", card_io_en, 0);
    step(1);
    chk("R4 io on after one step time", card_io_en, 1);
    step(u);
    chk("R5 reset held at clock start", card_rstn, 0);
    step(2 * u - 1);
    chk("R5 reset held to last cycle", card_rstn, 0);
    step(1);
    chk("R5 reset released after reset time", card_rstn, 1);
    pulse_act;
    chk("R10 activate while powered ignored", card_rstn, 1);
    step(98);
    io_line = 0;
    step(3);
    chk("R6 answer start seen", seen, 1);
    chk("R6 ready after answer start", ready, 1);
    io_line = 1; step(5); io_line = 0; step(5);
    chk("R10 edge outside window ignored (seen)", seen, 1);
    chk("R10 edge outside window ignored (timeout)", tmo, 0);
    io_line = 1; step(3);

    pulse_warm;
    chk("R8 warm reset pulls reset low", card_rstn, 0);
    chk("R8 warm reset keeps power", card_pwr, 1);
    step(2 * u - 1);
    chk("R8 warm reset held to last cycle", card_rstn, 0);
    step(1);
    chk("R8 warm reset released", card_rstn, 1);
    chk("R6 flags cleared at window open", seen, 0);
    step(3 * u - 1);
    chk("R7 no timeout before window end", tmo, 0);
    step(1);
    chk("R7 timeout at window end", tmo, 1);
    chk("R11 ready after timeout", ready, 1);

    pulse_deact;
    chk("R9 reset asserted on shutdown", card_rstn, 0);
    step(u);
    step(1);
    chk("R9 clock stopped after one step", card_clk, 0);
    chk("R9 io still on", card_io_en, 1);
    step(u - 1);
    chk("R9 io off after two steps", card_io_en, 0);
    chk("R9 power still on", card_pwr, 1);
    step(u);
    chk("R9 power off after three steps", card_pwr, 0);
    pulse_warm;
    chk("R10 warm request while off ignored", card_pwr, 0);
    pulse_deact;
    chk("R10 shutdown request while off ignored", card_rstn, 0);

    // ---- configuration 2: divisor 2, all fields 0 (one unit each) ----
    div = 16'd2; timing = 24'd0; u = 768;
    step(2);
    pulse_act;
    step(u - 1);
    chk("R3 io off before scaled unit", card_io_en, 0);
    step(1);
    chk("R3 zero step counts as one unit", card_io_en, 1);
    step(10);
    pulse_deact;
    chk("R9 shutdown during activation", card_rstn, 0);
    chk("R9 shutdown never raises clock", card_clk, 0);
    step(3 * u);
    chk("R9 power off after shutdown", card_pwr, 0);
    chk("R9 io off after shutdown", card_io_en, 0);

    pulse_act;
    step(3 * u);
    chk("R3 zero reset time gives one unit", card_rstn, 1);
    step(u - 1);
    chk("R7 window still open", tmo, 0);
    step(1);
    chk("R3 zero window gives one unit timeout", tmo, 1);

    rst = 1;
    step(2);
    chk("R1 reset mid-operation clears power", card_pwr, 0);
    chk("R1 reset mid-operation clears flags", tmo | ready, 0);
    rst = 0;
    step(4);
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cycles);
      finish_run;
    end
  end

endmodule